// File: doc/BRIEF.md
# Page Buffer Status and Interrupt Controller

This block keeps the bookkeeping state for a set of page buffers that sit between a host and a packet engine. Every buffer has two small state registers: a fill state that follows pages moving from host memory into the buffer, and a drain state that follows pages moving from the buffer out to host memory. The fetch and write-out datapaths around the block do not hold this state themselves. They send one-cycle state-change events into the block, along with the per-buffer accept and valid levels of the buffer array.

The host reads all buffer states in one request. A read whose command field selects status is answered with a completion that carries a word holding four bits per buffer. The block also raises an interrupt when the drain side needs the host: a buffer receiving a packet, or a page write-out finishing. The interrupt stays pending until the interrupt path reports ready or the host reads status.

Top module: `bufstat_irq_ctrl`

## Requirements
- R1: The command is the 2-bit field at request address bits [4:3]. Only code 00 (status) starts a completion. Codes 01 (send page), 10 (receive page) and 11 (management) leave the completion output low.
- R2: In the status word, buffer b holds its fill state in bits [4b+1:4b] and its drain state in bits [4b+3:4b+2]. A state is encoded 00 EMPTY, 01 ADDR, 10 DATA, 11 FULL. The word is a snapshot of the states as they stood at the clock edge that accepted the read.
- R3: An accepted status read raises cpl_valid on the next cycle. cpl_valid and cpl_data then hold, unchanged, until cpl_done is sampled high, and cpl_valid drops on the following cycle. A status read is not accepted while cpl_valid is high.
- R4: A fill event for buffer b writes its 2-bit kind into b's fill state, visible on the next cycle. Kinds 01, 10 and 11 mark address known, fetch in progress and fetch done.
- R5: A FULL fill state returns to EMPTY only after that buffer's accept input has been sampled low and then sampled high. While accept stays high without a preceding low, the state stays FULL.
- R6: When buffer b's valid input rises (sampled low, then sampled high), b's drain state becomes FULL and irq is high on the next cycle. A drain event for b in the same cycle sets the state instead.
- R7: A drain event for buffer b writes its kind into b's drain state on the next cycle. Kind 00 marks a finished page write-out and raises irq one cycle after the event. Kinds 01, 10 and 11 do not raise irq.
- R8: irq_ready high, or an accepted status read, clears a pending irq on the next cycle. A request that arrives in the same cycle as a clear keeps irq high. Several requests merge into one pending irq. Fill-side changes never raise irq.
- R9: After reset, every fill and drain state is EMPTY, and irq and cpl_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Host read request strobe |
| req_addr | input | ADDR_W (8) | Request address; bits [4:3] carry the command |
| cpl_done | input | 1 | Completion consumed by the host side |
| cpl_valid | output | 1 | Completion present |
| cpl_data | output | 4*NUM_BUF (64) | Packed status word |
| fill_evt_vld | input | 1 | Fill-side event strobe |
| fill_evt_kind | input | 2 | New fill state |
| fill_evt_buf | input | log2(NUM_BUF) (4) | Buffer index of the fill event |
| buf_accept | input | NUM_BUF (16) | Per-buffer accept level |
| drain_evt_vld | input | 1 | Drain-side event strobe |
| drain_evt_kind | input | 2 | New drain state; 00 means write-out finished |
| drain_evt_buf | input | log2(NUM_BUF) (4) | Buffer index of the drain event |
| buf_valid | input | NUM_BUF (16) | Per-buffer received-data level |
| irq_ready | input | 1 | Interrupt path has taken the interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default parameters: 16 buffers, an 8-bit request address and a 64-bit status word. With 16 buffers, the top field of the word (bits 63:60) and the full index range of both event buses are within reach. Random accept and valid toggles drive each buffer's release and rise detection on its own, so every buffer's fields move independently across the whole word. The 8-bit address lets random requests use all four command codes with junk in the bits outside the command field.

// File: rtl/bufstat_pkg.sv
package bufstat_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_ADDR  = 2'b01,
        ST_DATA  = 2'b10,
        ST_FULL  = 2'b11
    } buf_st_e;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'b00,
        CMD_SEND   = 2'b01,
        CMD_RECV   = 2'b10,
        CMD_MGMT   = 2'b11
    } host_cmd_e;

    localparam int CMD_LSB   = 3;
    localparam int FIELD_W   = 4;

endpackage

// File: rtl/fill_cell.sv
module fill_cell
    import bufstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_hit,
    input  logic [1:0] evt_kind,
    input  logic       accept,
    output buf_st_e    state
);

    typedef struct packed {
        buf_st_e st;
        logic    seen_low;
    } fill_reg_t;

    fill_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (evt_hit) begin
            r_d.st       = buf_st_e'(evt_kind);
            r_d.seen_low = 1'b0;
        end else if (r_q.st == ST_FULL) begin
            if (!accept) begin
                r_d.seen_low = 1'b1;
            end else if (r_q.seen_low) begin
                r_d.st       = ST_EMPTY;
                r_d.seen_low = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_EMPTY, seen_low: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

    // R4: the event kind lands in the state one cycle later
    a_r4_evt_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> (state == buf_st_e'($past(evt_kind))));

    // R5: FULL with no low accept seen stays FULL
    a_r5_full_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !r_q.seen_low && accept && !evt_hit) |=> (state == ST_FULL));

endmodule

// File: rtl/drain_cell.sv
module drain_cell
    import bufstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_hit,
    input  logic [1:0] evt_kind,
    input  logic       valid,
    output buf_st_e    state,
    output logic       irq_req
);

    typedef struct packed {
        buf_st_e st;
        logic    valid_q;
    } drain_reg_t;

    drain_reg_t r_d, r_q;
    logic       rise;

    always_comb begin
        rise        = valid && !r_q.valid_q;
        r_d         = r_q;
        r_d.valid_q = valid;
        if (evt_hit) begin
            r_d.st = buf_st_e'(evt_kind);
        end else if (rise) begin
            r_d.st = ST_FULL;
        end
        irq_req = rise || (evt_hit && (evt_kind == 2'b00));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_EMPTY, valid_q: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

    // R6: a valid rise with no competing event gives FULL next cycle
    a_r6_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !r_q.valid_q && !evt_hit) |=> (state == ST_FULL));

    // R7: the drain event kind lands in the state one cycle later
    a_r7_evt_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> (state == buf_st_e'($past(evt_kind))));

endmodule

// File: rtl/status_port.sv
module status_port
    import bufstat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cpl_done,
    input  logic [WORD_W-1:0] status_word,
    output logic              cpl_valid,
    output logic [WORD_W-1:0] cpl_data,
    output logic              rd_accept
);

    typedef struct packed {
        logic              v;
        logic [WORD_W-1:0] data;
    } cpl_reg_t;

    cpl_reg_t  c_d, c_q;
    host_cmd_e cmd;
    logic      unused_addr_bits;

    assign cmd = host_cmd_e'(req_addr[CMD_LSB +: 2]);
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:CMD_LSB+2], req_addr[CMD_LSB-1:0]};

    always_comb begin
        rd_accept = req_rd && (cmd == CMD_STATUS) && !c_q.v;
        c_d = c_q;
        if (rd_accept) begin
            c_d.v    = 1'b1;
            c_d.data = status_word;
        end else if (c_q.v && cpl_done) begin
            c_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cpl_valid = c_q.v;
    assign cpl_data  = c_q.data;

    // R3: accepted read gives a completion next cycle with the snapshot
    a_r3_cpl_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && cmd == CMD_STATUS && !cpl_valid) |=> (cpl_valid && cpl_data == $past(status_word)));

    // R3: completion holds until done is seen
    a_r3_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_done) |=> (cpl_valid && $stable(cpl_data)));

    // R3: completion drops after done
    a_r3_cpl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_done) |=> !cpl_valid);

    // R1: non-status commands do not start a completion
    a_r1_no_cpl_other_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpl_valid && !(req_rd && cmd == CMD_STATUS)) |=> !cpl_valid);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int NUM_REQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_vec,
    input  logic               clr_ready,
    input  logic               clr_read,
    output logic               irq
);

    typedef struct packed {
        logic pend;
    } irq_reg_t;

    irq_reg_t i_d, i_q;
    logic     any_req;

    always_comb begin
        any_req  = |req_vec;
        i_d      = i_q;
        i_d.pend = any_req || (i_q.pend && !(clr_ready || clr_read));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign irq = i_q.pend;

    // R8: any request leaves irq high next cycle, even alongside a clear
    a_r8_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |=> irq);

    // R8: a clear with no request drops irq
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (clr_ready || clr_read) && !(|req_vec)) |=> !irq);

    // R8: irq never rises without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(|req_vec)) |=> !irq);

endmodule

// File: rtl/bufstat_irq_ctrl.sv
module bufstat_irq_ctrl
    import bufstat_pkg::*;
#(
    parameter  int NUM_BUF = 16,
    parameter  int ADDR_W  = 8,
    localparam int IDX_W   = $clog2(NUM_BUF),
    localparam int WORD_W  = NUM_BUF * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rd,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               cpl_done,
    output logic               cpl_valid,
    output logic [WORD_W-1:0]  cpl_data,
    input  logic               fill_evt_vld,
    input  logic [1:0]         fill_evt_kind,
    input  logic [IDX_W-1:0]   fill_evt_buf,
    input  logic [NUM_BUF-1:0] buf_accept,
    input  logic               drain_evt_vld,
    input  logic [1:0]         drain_evt_kind,
    input  logic [IDX_W-1:0]   drain_evt_buf,
    input  logic [NUM_BUF-1:0] buf_valid,
    input  logic               irq_ready,
    output logic               irq
);

    logic [WORD_W-1:0]  status_word;
    logic [NUM_BUF-1:0] drain_req;
    logic               rd_accept;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        buf_st_e fill_st;
        buf_st_e drain_st;

        fill_cell u_fill (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_hit  (fill_evt_vld && (fill_evt_buf == IDX_W'(g))),
            .evt_kind (fill_evt_kind),
            .accept   (buf_accept[g]),
            .state    (fill_st)
        );

        drain_cell u_drain (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_hit  (drain_evt_vld && (drain_evt_buf == IDX_W'(g))),
            .evt_kind (drain_evt_kind),
            .valid    (buf_valid[g]),
            .state    (drain_st),
            .irq_req  (drain_req[g])
        );

        assign status_word[g*FIELD_W +: 2]     = fill_st;
        assign status_word[g*FIELD_W + 2 +: 2] = drain_st;
    end

    status_port #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_rd      (req_rd),
        .req_addr    (req_addr),
        .cpl_done    (cpl_done),
        .status_word (status_word),
        .cpl_valid   (cpl_valid),
        .cpl_data    (cpl_data),
        .rd_accept   (rd_accept)
    );

    irq_ctrl #(
        .NUM_REQ (NUM_BUF)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vec   (drain_req),
        .clr_ready (irq_ready),
        .clr_read  (rd_accept),
        .irq       (irq)
    );

    // R9: first cycle after reset is idle
    a_r9_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && !cpl_valid));

endmodule

// File: tb/sim_bufstat_irq_ctrl.sv
module sim_bufstat_irq_ctrl;

    localparam int NB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rd = 1'b0;
    logic [7:0]    req_addr = '0;
    logic          cpl_done = 1'b0;
    logic          cpl_valid;
    logic [63:0]   cpl_data;
    logic          fill_evt_vld = 1'b0;
    logic [1:0]    fill_evt_kind = '0;
    logic [3:0]    fill_evt_buf = '0;
    logic [NB-1:0] buf_accept = '1;
    logic          drain_evt_vld = 1'b0;
    logic [1:0]    drain_evt_kind = '0;
    logic [3:0]    drain_evt_buf = '0;
    logic [NB-1:0] buf_valid = '0;
    logic          irq_ready = 1'b0;
    logic          irq;

    bufstat_irq_ctrl u0 (.*);

    always #2 clk = ~clk;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    // bench reference model state
    int    m_fill [NB];
    bit    m_seen [NB];
    int    m_drain[NB];
    bit    m_vq   [NB];
    bit    m_irq;
    bit    m_cv;
    logic [63:0] m_cd;

    function automatic logic [63:0] model_word();
        logic [63:0] w = '0;
        for (int b = 0; b < NB; b++) begin
            w[4*b +: 2]   = m_fill[b][1:0];
            w[4*b+2 +: 2] = m_drain[b][1:0];
        end
        return w;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_fill[b] = 0; m_seen[b] = 0; m_drain[b] = 0; m_vq[b] = 0;
        end
        m_irq = 0; m_cv = 0; m_cd = '0;
    endtask

    // one clock: compute expected next state, clock, compare, return at negedge
    task automatic step();
        bit          acc, req;
        bit          n_cv;
        logic [63:0] n_cd;
        int          n_fill[NB], n_drain[NB];
        bit          n_seen[NB];
        acc  = req_rd && (req_addr[4:3] == 2'b00) && !m_cv;
        n_cv = m_cv; n_cd = m_cd;
        if (acc) begin n_cv = 1; n_cd = model_word(); end
        else if (m_cv && cpl_done) n_cv = 0;
        req = 0;
        for (int b = 0; b < NB; b++) begin
            bit fh, dh, rise;
            fh = fill_evt_vld && (fill_evt_buf == 4'(b));
            dh = drain_evt_vld && (drain_evt_buf == 4'(b));
            n_fill[b] = m_fill[b]; n_seen[b] = m_seen[b];
            if (fh) begin n_fill[b] = int'(fill_evt_kind); n_seen[b] = 0; end
            else if (m_fill[b] == 3) begin
                if (!buf_accept[b]) n_seen[b] = 1;
                else if (m_seen[b]) begin n_fill[b] = 0; n_seen[b] = 0; end
            end
            rise = buf_valid[b] && !m_vq[b];
            n_drain[b] = m_drain[b];
            if (dh) n_drain[b] = int'(drain_evt_kind);
            else if (rise) n_drain[b] = 3;
            if (rise || (dh && drain_evt_kind == 2'b00)) req = 1;
        end
        @(posedge clk);
        m_irq = req || (m_irq && !(irq_ready || acc));
        m_cv = n_cv; m_cd = n_cd;
        for (int b = 0; b < NB; b++) begin
            m_fill[b] = n_fill[b]; m_seen[b] = n_seen[b];
            m_drain[b] = n_drain[b]; m_vq[b] = buf_valid[b];
        end
        #1;
        check(64'(irq), 64'(m_irq), "R6/R7/R8 irq");
        check(64'(cpl_valid), 64'(m_cv), "R3 cpl_valid");
        if (m_cv) check(cpl_data, m_cd, "R2 cpl_data");
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_rd = 0; cpl_done = 0; fill_evt_vld = 0; drain_evt_vld = 0; irq_ready = 0;
    endtask

    task automatic do_read(output logic [63:0] w);
        idle_inputs();
        cpl_done = 1; step(); cpl_done = 0;
        req_rd = 1; req_addr = 8'h00; step(); req_rd = 0;
        w = cpl_data;
        cpl_done = 1; step(); cpl_done = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] w, held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R9: idle after reset
        check(64'(irq), 64'd0, "R9 irq after reset");
        check(64'(cpl_valid), 64'd0, "R9 cpl_valid after reset");
        @(negedge clk);
        do_read(w);
        check(w, 64'd0, "R9 all states EMPTY");

        // R1: non-status commands give no completion
        req_rd = 1; req_addr = 8'b0000_1000; step();
        check(64'(cpl_valid), 64'd0, "R1 send cmd no completion");
        req_addr = 8'b0001_1111; step();
        check(64'(cpl_valid), 64'd0, "R1 mgmt cmd no completion");
        req_addr = 8'b1110_0111; step(); req_rd = 0;
        check(64'(cpl_valid), 64'd1, "R1 status cmd with junk bits");
        cpl_done = 1; step(); cpl_done = 0;

        // R4: fill events write the state
        fill_evt_vld = 1; fill_evt_buf = 4'd2; fill_evt_kind = 2'b01; step();
        fill_evt_kind = 2'b10; step(); fill_evt_vld = 0;
        do_read(w);
        check(64'(w[9:8]), 64'd2, "R4 fill DATA in field 2");
        // R5: FULL held while accept stays high
        fill_evt_vld = 1; fill_evt_kind = 2'b11; step(); fill_evt_vld = 0;
        step(); step();
        do_read(w);
        check(64'(w[9:8]), 64'd3, "R5 fill FULL held");
        buf_accept[2] = 0; step(); step();
        do_read(w);
        check(64'(w[9:8]), 64'd3, "R5 FULL while accept low");
        buf_accept[2] = 1; step();
        do_read(w);
        check(64'(w[9:8]), 64'd0, "R5 EMPTY after low then high");

        // R8: fill changes never raise irq
        fill_evt_vld = 1; fill_evt_buf = 4'd7; fill_evt_kind = 2'b11; step(); fill_evt_vld = 0;
        check(64'(irq), 64'd0, "R8 fill event no irq");

        // R6: valid rise
        buf_valid[5] = 1; step();
        check(64'(irq), 64'd1, "R6 irq after valid rise");
        do_read(w);
        check(64'(w[23:22]), 64'd3, "R6 drain FULL in field 5");
        check(64'(irq), 64'd0, "R8 status read clears irq");

        // R7: drain events
        drain_evt_vld = 1; drain_evt_buf = 4'd5; drain_evt_kind = 2'b01; step();
        check(64'(irq), 64'd0, "R7 ADDR no irq");
        drain_evt_kind = 2'b10; step();
        check(64'(irq), 64'd0, "R7 DATA no irq");
        drain_evt_kind = 2'b00; step(); drain_evt_vld = 0;
        check(64'(irq), 64'd1, "R7 write-out done irq");
        irq_ready = 1; step(); irq_ready = 0;
        check(64'(irq), 64'd0, "R8 ready clears irq");

        // R8: request in the same cycle as clear stays pending
        drain_evt_vld = 1; drain_evt_buf = 4'd15; drain_evt_kind = 2'b00; step();
        irq_ready = 1; step(); drain_evt_vld = 0;
        check(64'(irq), 64'd1, "R8 request with clear kept");
        step(); irq_ready = 0;
        check(64'(irq), 64'd0, "R8 clear after merge");

        // R3: completion hold and drop
        req_rd = 1; req_addr = 8'h00; step(); req_rd = 0;
        held = cpl_data;
        fill_evt_vld = 1; fill_evt_buf = 4'd15; fill_evt_kind = 2'b01; step(); fill_evt_vld = 0;
        req_rd = 1; step(); req_rd = 0; step();
        check(64'(cpl_valid), 64'd1, "R3 valid held");
        check(cpl_data, held, "R3 data held");
        cpl_done = 1; step(); cpl_done = 0;
        check(64'(cpl_valid), 64'd0, "R3 drop after done");
        do_read(w);
        check(64'(w[61:60]), 64'd1, "R2 top field fill ADDR");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            req_rd         = ($urandom_range(3) == 0);
            req_addr       = 8'($urandom);
            cpl_done       = ($urandom_range(2) == 0);
            fill_evt_vld   = ($urandom_range(3) == 0);
            fill_evt_kind  = 2'($urandom);
            fill_evt_buf   = 4'($urandom);
            drain_evt_vld  = ($urandom_range(5) == 0);
            drain_evt_kind = 2'($urandom);
            drain_evt_buf  = 4'($urandom);
            irq_ready      = ($urandom_range(7) == 0);
            if ($urandom_range(3) == 0) buf_accept[$urandom_range(NB-1)] ^= 1'b1;
            if ($urandom_range(5) == 0) buf_valid[$urandom_range(NB-1)] ^= 1'b1;
            step();
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule